// File: doc/BRIEF.md
# Idle Column Rate Matcher

This block sits behind lane deskew on a four-lane, byte-per-lane column datapath. Each column carries four data bytes and four control flags. Columns arrive on a write strobe that follows the recovered clock's rate. A local consumer takes columns on a read strobe that follows the local clock's rate. Between the two sits a small insert/delete FIFO. While the link reports lane lock, the block keeps the FIFO near half full. When the FIFO runs high, it drops an incoming column made only of idle fill characters. When it runs low, it emits an extra idle fill column without consuming one.

Only whole four-lane idle columns are ever added or removed. At most one adjustment is made on each side per inter-packet gap, so packet bytes and end-of-packet control bytes pass through untouched. An overflow or underflow is recorded in a sticky error flag. The FIFO then re-centres itself holding half its depth of idle columns. This is also the state the FIFO starts in after reset.

Top module: `rm_rate_match`

## Requirements
- R1: After reset the output column is an idle column (all four control flags set, every byte equal to the idle code 0x1C), the insert, delete and error outputs are low, and the FIFO holds DEPTH/2 idle columns.
- R2: Columns that are not added or removed leave the FIFO in write order. A column requested by out_rd appears on out_ctl/out_data in the cycle after the request and holds until the next request.
- R3: With lane_locked high, an incoming idle column written while the fill level exceeds HI_MARK is discarded, and del_pulse is high for one cycle in the cycle after.
- R4: With lane_locked high, a read made while the fill level is below LO_MARK and the head column is idle outputs an idle column without consuming the head, and ins_pulse is high for one cycle in the cycle after.
- R5: After a deletion, no further deletion happens until a non-idle column has been written. After an insertion, no further insertion happens until a non-idle column has been read out.
- R6: With lane_locked low, no column is inserted or deleted, whatever the fill level.
- R7: A column with any control flag clear, or any byte different from the idle code, is never deleted, even above HI_MARK.
- R8: A write into a full FIFO with no read (overflow), or a read from an empty FIFO (underflow), sets err_sticky until reset. The access is dropped, an underflowing read outputs an idle column, and the FIFO then holds DEPTH/2 idle columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lane_locked | input | 1 | Lanes synchronized and deskewed; enables rate adjustment |
| in_wr | input | 1 | A deskewed column is presented this cycle |
| in_ctl | input | 4 | Per-lane control flags of the incoming column |
| in_data | input | 32 | Incoming column bytes, lane 0 in bits 7:0 |
| out_rd | input | 1 | Local side takes one column this cycle |
| out_ctl | output | 4 | Per-lane control flags of the output column |
| out_data | output | 32 | Output column bytes |
| ins_pulse | output | 1 | An idle column was inserted |
| del_pulse | output | 1 | An idle column was deleted |
| err_sticky | output | 1 | Overflow or underflow has occurred since reset |

## Verification
The bench builds the block with its default DEPTH of 16, HI_MARK of 12 and LO_MARK of 4. With these values, a handful of unmatched writes or reads drives the fill level across either watermark. A few more reach overflow and underflow. As a result, deletion, insertion, the once-per-gap limit, the unlocked case and both error recoveries all fit in short directed sequences. A reference queue model in the bench predicts every output column and pulse.

// File: rtl/rm_pkg.sv
package rm_pkg;
  parameter int LANES  = 4;
  parameter int BYTE_W = 8;
  localparam int COL_W = LANES * BYTE_W;

  typedef struct packed {
    logic [LANES-1:0] ctl;
    logic [COL_W-1:0] dat;
  } col_t;

  function automatic col_t idle_col(input logic [BYTE_W-1:0] code);
    col_t c;
    c.ctl = '1;
    c.dat = {LANES{code}};
    return c;
  endfunction
endpackage

// File: rtl/rm_idle_detect.sv
module rm_idle_detect import rm_pkg::*; #(
  parameter logic [BYTE_W-1:0] IDLE_CODE = 8'h1C
) (
  input  col_t col,
  output logic is_idle
);
  logic [LANES-1:0] lane_idle;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_idle[g] = col.ctl[g] && (col.dat[g*BYTE_W +: BYTE_W] == IDLE_CODE);
  end

  assign is_idle = &lane_idle;
endmodule

// File: rtl/rm_col_store.sv
module rm_col_store import rm_pkg::*; #(
  parameter int DEPTH = 16,
  parameter logic [BYTE_W-1:0] IDLE_CODE = 8'h1C,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  col_t             wr_col,
  input  logic             refill,
  input  logic [PTR_W-1:0] rd_addr,
  output col_t             rd_col
);
  col_t rows_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < DEPTH; r++) rows_q[r] <= idle_col(IDLE_CODE);
    end else if (refill) begin
      for (int r = 0; r < DEPTH; r++) rows_q[r] <= idle_col(IDLE_CODE);
    end else if (wr_en) begin
      rows_q[wr_addr] <= wr_col;
    end
  end

  assign rd_col = rows_q[rd_addr];
endmodule

// File: rtl/rm_level_ctl.sv
module rm_level_ctl #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] fill,
  output logic             ovf,
  output logic             unf
);
  localparam logic [CNT_W-1:0] FULL_L = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_L = CNT_W'(DEPTH / 2);
  localparam logic [PTR_W-1:0] HALF_P = PTR_W'(DEPTH / 2);

  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] fill_q, fill_d;

  assign unf = pop && (fill_q == '0);
  assign ovf = push && (fill_q == FULL_L) && !pop;

  always_comb begin
    wr_d   = wr_q;
    rd_d   = rd_q;
    fill_d = fill_q;
    if (ovf || unf) begin
      rd_d   = '0;
      wr_d   = HALF_P;
      fill_d = HALF_L;
    end else begin
      if (push) wr_d = wr_q + PTR_W'(1);
      if (pop)  rd_d = rd_q + PTR_W'(1);
      fill_d = fill_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= HALF_P;
      rd_q   <= '0;
      fill_q <= HALF_L;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      fill_q <= fill_d;
    end
  end

  assign wr_ptr = wr_q;
  assign rd_ptr = rd_q;
  assign fill   = fill_q;
endmodule

// File: rtl/rm_rate_match.sv
module rm_rate_match import rm_pkg::*; #(
  parameter int DEPTH   = 16,
  parameter int HI_MARK = 12,
  parameter int LO_MARK = 4,
  parameter logic [BYTE_W-1:0] IDLE_CODE = 8'h1C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lane_locked,
  input  logic             in_wr,
  input  logic [LANES-1:0] in_ctl,
  input  logic [COL_W-1:0] in_data,
  input  logic             out_rd,
  output logic [LANES-1:0] out_ctl,
  output logic [COL_W-1:0] out_data,
  output logic             ins_pulse,
  output logic             del_pulse,
  output logic             err_sticky
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] HI_L = CNT_W'(HI_MARK);
  localparam logic [CNT_W-1:0] LO_L = CNT_W'(LO_MARK);

  // reset synchronizer: assert async, release on clock
  logic [1:0] rsync_q;
  logic       core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  col_t             in_col, head_col, out_q, out_d;
  logic             in_idle, head_idle;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] fill;
  logic             ovf, unf, recover;
  logic             del_now, ins_now, push, pop;
  logic             del_used_q, del_used_d, ins_used_q, ins_used_d;
  logic             ins_q, del_q, err_q, err_d;

  assign in_col = '{ctl: in_ctl, dat: in_data};

  rm_idle_detect #(.IDLE_CODE(IDLE_CODE)) i_in_det (
    .col(in_col), .is_idle(in_idle)
  );
  rm_idle_detect #(.IDLE_CODE(IDLE_CODE)) i_head_det (
    .col(head_col), .is_idle(head_idle)
  );

  // rate decisions
  assign del_now = lane_locked && in_wr && in_idle && (fill > HI_L) && !del_used_q;
  assign push    = in_wr && !del_now;
  assign ins_now = lane_locked && out_rd && head_idle && (fill != '0) &&
                   (fill < LO_L) && !ins_used_q;
  assign pop     = out_rd && !ins_now;
  assign recover = ovf || unf;

  rm_level_ctl #(.DEPTH(DEPTH)) i_level (
    .clk(clk), .rst_n(core_rst_n), .push(push), .pop(pop),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .fill(fill), .ovf(ovf), .unf(unf)
  );

  rm_col_store #(.DEPTH(DEPTH), .IDLE_CODE(IDLE_CODE)) i_store (
    .clk(clk), .rst_n(core_rst_n), .wr_en(push && !recover), .wr_addr(wr_ptr),
    .wr_col(in_col), .refill(recover), .rd_addr(rd_ptr), .rd_col(head_col)
  );

  always_comb begin
    out_d = out_q;
    if (out_rd) out_d = (ins_now || unf) ? idle_col(IDLE_CODE) : head_col;

    del_used_d = del_used_q;
    if (del_now)                 del_used_d = 1'b1;
    else if (in_wr && !in_idle)  del_used_d = 1'b0;

    ins_used_d = ins_used_q;
    if (ins_now)                         ins_used_d = 1'b1;
    else if (pop && !unf && !head_idle)  ins_used_d = 1'b0;

    err_d = err_q || recover;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      out_q      <= idle_col(IDLE_CODE);
      del_used_q <= 1'b0;
      ins_used_q <= 1'b0;
      ins_q      <= 1'b0;
      del_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      out_q      <= out_d;
      del_used_q <= del_used_d;
      ins_used_q <= ins_used_d;
      ins_q      <= ins_now;
      del_q      <= del_now;
      err_q      <= err_d;
    end
  end

  assign out_ctl    = out_q.ctl;
  assign out_data   = out_q.dat;
  assign ins_pulse  = ins_q;
  assign del_pulse  = del_q;
  assign err_sticky = err_q;
endmodule

// File: rtl/rm_rate_match_chk.sv
module rm_rate_match_chk import rm_pkg::*; #(
  parameter logic [BYTE_W-1:0] IDLE_CODE = 8'h1C
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lane_locked,
  input logic             in_wr,
  input logic [LANES-1:0] in_ctl,
  input logic [COL_W-1:0] in_data,
  input logic             out_rd,
  input logic [LANES-1:0] out_ctl,
  input logic [COL_W-1:0] out_data,
  input logic             ins_pulse,
  input logic             del_pulse,
  input logic             err_sticky
);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  assert_del_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    del_pulse |-> ($past(in_wr) && ($past(in_ctl) == '1) &&
                   ($past(in_data) == {LANES{IDLE_CODE}})));

  assert_ins_emits_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_pulse |-> ((out_ctl == '1) && (out_data == {LANES{IDLE_CODE}}) && $past(out_rd)));

  assert_no_adjust_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_pulse || del_pulse) |-> $past(lane_locked));

  assert_del_once_per_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    del_pulse |=> !del_pulse);

  assert_ins_once_per_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_pulse |=> !ins_pulse);

  assert_out_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(out_rd) |-> ($stable(out_ctl) && $stable(out_data)));
endmodule

bind rm_rate_match rm_rate_match_chk #(.IDLE_CODE(IDLE_CODE)) i_chk (
  .clk(clk), .rst_n(rst_n), .lane_locked(lane_locked), .in_wr(in_wr),
  .in_ctl(in_ctl), .in_data(in_data), .out_rd(out_rd), .out_ctl(out_ctl),
  .out_data(out_data), .ins_pulse(ins_pulse), .del_pulse(del_pulse),
  .err_sticky(err_sticky)
);

// File: tb/test_rm_rate_match.sv
`timescale 1ns/1ps
module test_rm_rate_match;
  localparam int DEPTH = 16, HI = 12, LO = 4;
  localparam logic [35:0] RCOL = {4'hF, {4{8'h1C}}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic lane_locked = 1'b0, in_wr = 1'b0, out_rd = 1'b0;
  logic [3:0]  in_ctl = 4'h0;
  logic [31:0] in_data = '0;
  logic [3:0]  out_ctl;
  logic [31:0] out_data;
  logic ins_pulse, del_pulse, err_sticky;

  int checks = 0, errors = 0;
  logic [38:0] exp_q[$];
  string       tag_q[$];
  logic [35:0] mq[$];
  logic [35:0] m_out;
  bit m_del_used, m_ins_used, m_err;

  always #2 clk = ~clk;

  rm_rate_match i_rm_rate_match (
    .clk(clk), .rst_n(rst_n), .lane_locked(lane_locked), .in_wr(in_wr),
    .in_ctl(in_ctl), .in_data(in_data), .out_rd(out_rd), .out_ctl(out_ctl),
    .out_data(out_data), .ins_pulse(ins_pulse), .del_pulse(del_pulse),
    .err_sticky(err_sticky)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each predicted cycle just after the edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [38:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk({t, " R2 column"}, 64'({out_ctl, out_data}), 64'(e[38:3]));
      chk({t, " R4 ins_pulse"}, 64'(ins_pulse), 64'(e[2]));
      chk({t, " R3 del_pulse"}, 64'(del_pulse), 64'(e[1]));
      chk({t, " R8 err_sticky"}, 64'(err_sticky), 64'(e[0]));
    end
  end

  // driver with reference model pushing expected items
  task automatic cyc(input bit wr, input logic [35:0] col, input bit rd, input string tag);
    int  fill;
    bit  col_r, del, push, head_r, ins, pop, unf, ovf;
    @(negedge clk);
    in_wr = wr; in_ctl = col[35:32]; in_data = col[31:0]; out_rd = rd;
    fill   = mq.size();
    col_r  = (col == RCOL);
    del    = lane_locked && wr && col_r && fill > HI && !m_del_used;
    push   = wr && !del;
    head_r = fill > 0 && mq[0] == RCOL;
    ins    = lane_locked && rd && head_r && fill < LO && !m_ins_used;
    pop    = rd && !ins;
    unf    = pop && fill == 0;
    ovf    = push && fill == DEPTH && !pop;
    if (rd) m_out = (ins || unf) ? RCOL : mq[0];
    if (del) m_del_used = 1;
    else if (wr && !col_r) m_del_used = 0;
    if (ins) m_ins_used = 1;
    else if (pop && fill > 0 && mq[0] != RCOL) m_ins_used = 0;
    m_err = m_err | unf | ovf;
    if (unf || ovf) begin
      mq.delete();
      for (int i = 0; i < DEPTH/2; i++) mq.push_back(RCOL);
    end else begin
      if (pop)  void'(mq.pop_front());
      if (push) mq.push_back(col);
    end
    exp_q.push_back({m_out, ins, del, m_err});
    tag_q.push_back(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_wr = 1'b0; out_rd = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mq.delete();
    for (int i = 0; i < DEPTH/2; i++) mq.push_back(RCOL);
    m_out = RCOL; m_del_used = 0; m_ins_used = 0; m_err = 0;
    chk("R1 reset column", 64'({out_ctl, out_data}), 64'(RCOL));
    chk("R1 reset ins/del", 64'({ins_pulse, del_pulse}), 64'(0));
    chk("R1 reset err", 64'(err_sticky), 64'(0));
  endtask

  function automatic logic [35:0] dcol(input int n);
    return {4'h0, 32'(n) ^ 32'hA5A5_0000};
  endfunction

  localparam logic [35:0] TCOL = {4'b0001, 24'h1C1C1C, 8'hFD};

  initial begin
    do_reset();
    lane_locked = 1'b1;
    // R2/R1: eight idle columns come out first, then data in order
    for (int i = 0; i < 12; i++) cyc(1, dcol(i), 1, "R2 passthrough");
    // R3/R7/R5: fill high
    for (int i = 0; i < 5; i++) cyc(1, dcol(100 + i), 0, "R3 fill");
    cyc(1, TCOL, 0, "R7 end column kept");
    cyc(1, RCOL, 0, "R3 idle deleted");
    cyc(1, RCOL, 0, "R5 second idle kept");
    cyc(1, dcol(200), 0, "R5 gap ends");
    cyc(1, RCOL, 0, "R3 new gap delete");
    cyc(1, RCOL, 0, "R8 overflow");
    for (int i = 0; i < 3; i++) cyc(0, RCOL, 0, "R8 sticky");
    for (int i = 0; i < 9; i++) cyc(0, RCOL, 1, "R8 recentred");

    do_reset();
    lane_locked = 1'b1;
    for (int i = 0; i < 5; i++) cyc(0, RCOL, 1, "R1 drain");
    cyc(0, RCOL, 1, "R4 insert");
    cyc(0, RCOL, 1, "R5 no second insert");
    cyc(0, RCOL, 1, "R5 drain");
    cyc(1, dcol(300), 1, "R5 still same gap");
    cyc(0, RCOL, 1, "R2 data out");
    cyc(1, RCOL, 0, "R4 refill");
    cyc(0, RCOL, 1, "R4 insert new gap");
    cyc(0, RCOL, 1, "R2 drain");
    cyc(0, RCOL, 1, "R8 underflow");
    for (int i = 0; i < 2; i++) cyc(0, RCOL, 0, "R8 sticky");

    do_reset();
    lane_locked = 1'b0;
    for (int i = 0; i < 8; i++) cyc(1, RCOL, 0, "R6 no delete");
    for (int i = 0; i < 15; i++) cyc(0, RCOL, 1, "R6 no insert");
    for (int i = 0; i < 3; i++) cyc(0, RCOL, 0, "R6 idle");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule